// File: doc/BRIEF.md
# System Clock Source Switcher with Slewed Post-Divider

This block picks the system clock from a set of up to eight oscillator sources and holds a 4-bit post-divide setting. Software writes a source code and sets a go bit in the control register. The block checks that the chosen source reports ready and rejects the request if it does not. On an accepted request it waits for the running source to sit low, closes the output gate, then waits for the new source to sit low, and only then moves the selection and reopens the gate. No shortened pulse can reach the output. The go bit reads back as set while a changeover is pending and clears by itself.

The post-divider has a target ratio code and an applied ratio code. When stepping is enabled for the direction of a change, the applied code moves by one every (interval + 1) cycles until it meets the target. Otherwise it takes the target on the next cycle. A busy bit reads as set while the two codes differ. The applied code drives a tick generator that pulses once every (code + 1) cycles.

Source clocks arrive as levels. They are retimed into the block clock through a synchronizer of configurable depth. The output clock is the retimed level of the selected source, gated. Each source must therefore run several times slower than the block clock. The register bus is single-cycle: a write takes effect at the clock edge it is presented on, and read data always shows the register picked by the address, whether or not the select is asserted.

Top module: `sysclk_switcher`

## Requirements
- R1: After reset the control register reads the reset source code in bits 14:12, a requested code of that same value in bits 10:8, and go (bit 0) clear. The slew register reads zero, and the applied ratio equals the reset ratio.
- R2: A control write with bit 0 set whose code in bits 10:8 names a source with its ready input low is rejected. Go never reads set, bits 14:12 keep the old code, and bits 10:8 show the written code.
- R3: A request for the source already running finishes at once: go stays clear and the selection is unchanged.
- R4: An accepted request sets go (bit 0) from the cycle after the write. When the new source has been seen low, bits 14:12 take the new code and go clears.
- R5: The output clock is the gated, retimed level of the current source. It stays low from the cycle the old source is seen low until the new source is seen low.
- R6: Control writes that arrive while go is set are ignored entirely, including the requested code.
- R7: A slew write sets the target in bits 23:20, the interval in bits 15:8, down stepping in bit 1 and up stepping in bit 2. With stepping disabled for that direction, the applied ratio equals the target one cycle after the write.
- R8: With stepping enabled for the direction of change, the applied ratio moves by exactly one. The first step comes (interval + 1) cycles after the write, and each later step follows (interval + 1) cycles after the one before.
- R9: Bit 0 of the slew register reads 1 exactly while the applied ratio differs from the target.
- R10: div_tick_o pulses once every (applied ratio + 1) cycles. It is high on every cycle when the ratio is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 1 | 0 = control register, 1 = slew register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| src_clk_i | input | NSRC | Source clock levels |
| src_ready_i | input | NSRC | Per-source ready flags |
| sys_clk_o | output | 1 | Gated, retimed system clock |
| div_tick_o | output | 1 | Post-divider tick |
| div_ratio_o | output | 4 | Applied ratio code (divide by code + 1) |

## Verification
- **Register reads:** read data is combinational on registers that update at the write edge, so a written field is due at the first falling edge after that write.
- **Switch completion:** completion depends on the source phases seen through the synchronizer, so the go bit is polled with a bound rather than expected on a fixed cycle.
- **Divider:** a ratio step is due exactly (interval + 1) edges after the write or after the previous step, and directed checks wait that exact number of falling edges.
- **Reference model:** a behavioural model in the bench, including its own history of sampled source levels, predicts the output clock, tick, ratio and read data. Every output is compared on each falling edge, half a period after the edge that produced it.

// File: rtl/sysclk_sw_pkg.sv
package sysclk_sw_pkg;
   localparam int CODE_W = 3;
   localparam int CODES  = 1 << CODE_W;
   localparam int DIV_W  = 4;

   // control register layout
   localparam int CTRL_GO_BIT  = 0;
   localparam int CTRL_REQ_LSB = 8;
   localparam int CTRL_CUR_LSB = 12;

   // slew register layout
   localparam int SLEW_BUSY_BIT = 0;
   localparam int SLEW_DN_BIT   = 1;
   localparam int SLEW_UP_BIT   = 2;
   localparam int SLEW_STEP_LSB = 8;
   localparam int SLEW_DIV_LSB  = 20;

   typedef enum logic [1:0] {
      SW_IDLE    = 2'd0,
      SW_OLD_LOW = 2'd1,
      SW_NEW_LOW = 2'd2
   } sw_state_e;
endpackage

// File: rtl/sysclk_lvl_sync.sv
module sysclk_lvl_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] lvl_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl_o = lvl_i;
      end else begin : g_pipe
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= lvl_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign lvl_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sysclk_switch_fsm.sv
module sysclk_switch_fsm
   import sysclk_sw_pkg::*;
#(
   parameter int NSRC      = 8,
   parameter int RESET_SRC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [CODE_W-1:0] tgt_i,
   input  logic [NSRC-1:0]   ready_i,
   input  logic [NSRC-1:0]   lvl_i,
   output logic [CODE_W-1:0] cur_o,
   output logic              gate_o,
   output logic              pend_o,
   output sw_state_e         state_o
);
   logic [CODES-1:0]  rdy_x;
   logic [CODES-1:0]  lvl_x;
   logic [CODE_W-1:0] tgt_q;
   logic              accept;

   assign rdy_x  = CODES'(ready_i);
   assign lvl_x  = CODES'(lvl_i);
   assign accept = go_i && (state_o == SW_IDLE) && rdy_x[tgt_i] && (tgt_i != cur_o);
   assign pend_o = (state_o != SW_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= SW_IDLE;
         cur_o   <= CODE_W'(RESET_SRC);
         gate_o  <= 1'b1;
         tgt_q   <= '0;
      end else begin
         case (state_o)
            SW_IDLE: begin
               if (accept) begin
                  tgt_q   <= tgt_i;
                  state_o <= SW_OLD_LOW;
               end
            end
            SW_OLD_LOW: begin
               if (!lvl_x[cur_o]) begin
                  gate_o  <= 1'b0;
                  state_o <= SW_NEW_LOW;
               end
            end
            SW_NEW_LOW: begin
               if (!lvl_x[tgt_q]) begin
                  cur_o   <= tgt_q;
                  gate_o  <= 1'b1;
                  state_o <= SW_IDLE;
               end
            end
            default: state_o <= SW_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sysclk_slew_div.sv
module sysclk_slew_div
   import sysclk_sw_pkg::*;
#(
   parameter int STEP_W    = 8,
   parameter int RESET_DIV = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DIV_W-1:0]  tgt_i,
   input  logic              up_i,
   input  logic              dn_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [DIV_W-1:0]  tgt_o,
   output logic [DIV_W-1:0]  cur_o,
   output logic              up_o,
   output logic              dn_o,
   output logic [STEP_W-1:0] step_o
);
   logic [STEP_W-1:0] cnt_q;
   logic              rising;
   logic              slewing;

   assign rising  = (tgt_o > cur_o);
   assign slewing = rising ? up_o : dn_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_o  <= DIV_W'(RESET_DIV);
         cur_o  <= DIV_W'(RESET_DIV);
         up_o   <= 1'b0;
         dn_o   <= 1'b0;
         step_o <= '0;
         cnt_q  <= '0;
      end else if (wr_i) begin
         tgt_o  <= tgt_i;
         up_o   <= up_i;
         dn_o   <= dn_i;
         step_o <= step_i;
         cnt_q  <= '0;
      end else if (cur_o != tgt_o) begin
         if (!slewing) begin
            cur_o <= tgt_o;
         end else if (cnt_q == step_o) begin
            cnt_q <= '0;
            cur_o <= rising ? cur_o + 1'b1 : cur_o - 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sysclk_tick_gen.sv
module sysclk_tick_gen #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ratio_i,
   output logic         tick_o
);
   logic [W-1:0] tcnt_q;

   assign tick_o = (tcnt_q >= ratio_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tcnt_q <= '0;
      else if (tick_o) tcnt_q <= '0;
      else             tcnt_q <= tcnt_q + 1'b1;
   end
endmodule

// File: rtl/sysclk_switcher.sv
module sysclk_switcher
   import sysclk_sw_pkg::*;
#(
   parameter int NSRC        = 8,
   parameter int RESET_SRC   = 0,
   parameter int SYNC_STAGES = 2,
   parameter int STEP_W      = 8,
   parameter int RESET_DIV   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_i,
   input  logic              bus_we_i,
   input  logic              bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic [NSRC-1:0]   src_clk_i,
   input  logic [NSRC-1:0]   src_ready_i,
   output logic              sys_clk_o,
   output logic              div_tick_o,
   output logic [DIV_W-1:0]  div_ratio_o
);
   initial begin
      assert (NSRC >= 2 && NSRC <= CODES) else $error("NSRC out of range");
      assert (RESET_SRC >= 0 && RESET_SRC < NSRC) else $error("RESET_SRC out of range");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (STEP_W >= 1 && SLEW_STEP_LSB + STEP_W <= SLEW_DIV_LSB) else $error("STEP_W out of range");
      assert (RESET_DIV >= 0 && RESET_DIV < (1 << DIV_W)) else $error("RESET_DIV out of range");
   end

   logic              ctrl_wr, slew_wr, go;
   logic [CODE_W-1:0] req_src, cur_src;
   logic              sw_pend, gate_en;
   sw_state_e         sw_state;
   logic [NSRC-1:0]   lvl_sync;
   logic [CODES-1:0]  lvl_x;
   logic [DIV_W-1:0]  div_tgt, div_cur;
   logic              slew_up, slew_dn;
   logic [STEP_W-1:0] slew_step;
   logic              unused_wdata;

   assign ctrl_wr = bus_sel_i && bus_we_i && !bus_addr_i;
   assign slew_wr = bus_sel_i && bus_we_i &&  bus_addr_i;
   assign go      = ctrl_wr && !sw_pend && bus_wdata_i[CTRL_GO_BIT];
   assign unused_wdata = ^bus_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  req_src <= CODE_W'(RESET_SRC);
      else if (ctrl_wr && !sw_pend) req_src <= bus_wdata_i[CTRL_REQ_LSB +: CODE_W];
   end

   sysclk_lvl_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (src_clk_i),
      .lvl_o (lvl_sync)
   );

   sysclk_switch_fsm #(.NSRC(NSRC), .RESET_SRC(RESET_SRC)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (go),
      .tgt_i   (bus_wdata_i[CTRL_REQ_LSB +: CODE_W]),
      .ready_i (src_ready_i),
      .lvl_i   (lvl_sync),
      .cur_o   (cur_src),
      .gate_o  (gate_en),
      .pend_o  (sw_pend),
      .state_o (sw_state)
   );

   sysclk_slew_div #(.STEP_W(STEP_W), .RESET_DIV(RESET_DIV)) u_slew (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (slew_wr),
      .tgt_i  (bus_wdata_i[SLEW_DIV_LSB +: DIV_W]),
      .up_i   (bus_wdata_i[SLEW_UP_BIT]),
      .dn_i   (bus_wdata_i[SLEW_DN_BIT]),
      .step_i (bus_wdata_i[SLEW_STEP_LSB +: STEP_W]),
      .tgt_o  (div_tgt),
      .cur_o  (div_cur),
      .up_o   (slew_up),
      .dn_o   (slew_dn),
      .step_o (slew_step)
   );

   sysclk_tick_gen #(.W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .ratio_i (div_cur),
      .tick_o  (div_tick_o)
   );

   assign lvl_x       = CODES'(lvl_sync);
   assign sys_clk_o   = gate_en && lvl_x[cur_src];
   assign div_ratio_o = div_cur;

   always_comb begin
      bus_rdata_o = '0;
      if (!bus_addr_i) begin
         bus_rdata_o[CTRL_GO_BIT]                 = sw_pend;
         bus_rdata_o[CTRL_REQ_LSB +: CODE_W]      = req_src;
         bus_rdata_o[CTRL_CUR_LSB +: CODE_W]      = cur_src;
      end else begin
         bus_rdata_o[SLEW_BUSY_BIT]               = (div_cur != div_tgt);
         bus_rdata_o[SLEW_DN_BIT]                 = slew_dn;
         bus_rdata_o[SLEW_UP_BIT]                 = slew_up;
         bus_rdata_o[SLEW_STEP_LSB +: STEP_W]     = slew_step;
         bus_rdata_o[SLEW_DIV_LSB +: DIV_W]       = div_tgt;
      end
   end
endmodule

// File: rtl/sysclk_switcher_chk.sv
module sysclk_switcher_chk
   import sysclk_sw_pkg::*;
#(
   parameter int NSRC = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel_i,
   input logic              bus_we_i,
   input logic              bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic [31:0]       bus_rdata_o,
   input logic [NSRC-1:0]   src_ready_i,
   input logic              sys_clk_o,
   input logic              div_tick_o,
   input logic [DIV_W-1:0]  div_ratio_o,
   input sw_state_e         sw_state,
   input logic [CODE_W-1:0] cur_src,
   input logic [CODE_W-1:0] req_src,
   input logic              sw_pend,
   input logic [DIV_W-1:0]  div_tgt,
   input logic              slew_up
);
   logic              c_cw, c_sw;
   logic [CODE_W-1:0] c_code;
   logic [CODES-1:0]  c_rdy;

   assign c_cw   = bus_sel_i && bus_we_i && !bus_addr_i;
   assign c_sw   = bus_sel_i && bus_we_i &&  bus_addr_i;
   assign c_code = bus_wdata_i[CTRL_REQ_LSB +: CODE_W];
   assign c_rdy  = CODES'(src_ready_i);

   // R2: a request to a source that is not ready leaves the selection alone
   a_r2_reject_unready: assert property (@(posedge clk) disable iff (!rst_n)
      (c_cw && !sw_pend && bus_wdata_i[0] && !c_rdy[c_code])
      |=> (cur_src == $past(cur_src)) && !sw_pend);

   // R3: a request for the running source completes at once
   a_r3_same_source: assert property (@(posedge clk) disable iff (!rst_n)
      (c_cw && !sw_pend && bus_wdata_i[0] && c_code == cur_src) |=> !sw_pend);

   // R5: output held low while waiting for the new source
   a_r5_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_state == SW_NEW_LOW) |-> !sys_clk_o);

   // R4: selection only moves while a switch is pending
   a_r4_cur_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_pend) |=> (cur_src == $past(cur_src)));

   // R6: control writes during a pending switch are ignored
   a_r6_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (c_cw && sw_pend) |=> (req_src == $past(req_src)));

   // R8: an upward slew moves by at most one per cycle
   a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_sw && slew_up && div_ratio_o < div_tgt)
      |=> (div_ratio_o == $past(div_ratio_o) || div_ratio_o == $past(div_ratio_o) + 4'd1));

   // R9: busy bit tracks the ratio mismatch
   a_r9_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_i |-> (bus_rdata_o[0] == (div_ratio_o != div_tgt)));

   // R10: no back-to-back ticks unless the ratio is zero
   a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (div_tick_o && div_ratio_o != '0) |=> (!div_tick_o || div_ratio_o == '0));
endmodule

bind sysclk_switcher sysclk_switcher_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/sysclk_switcher_bench.sv
module sysclk_switcher_bench;
   localparam int NSRC = 8;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NSRC-1:0] src_clk = '0;
   logic [NSRC-1:0] src_ready = 8'h3F;
   logic        sys_clk, div_tick;
   logic [3:0]  div_ratio;

   always #2.5 clk = ~clk;

   sysclk_switcher u_sysclk_switcher (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .src_clk_i(src_clk), .src_ready_i(src_ready), .sys_clk_o(sys_clk),
      .div_tick_o(div_tick), .div_ratio_o(div_ratio)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // source clocks: source i has a half period of 3+2*i block cycles
   int hc [NSRC];
   initial for (int i = 0; i < NSRC; i++) hc[i] = 0;
   always @(negedge clk) begin
      #1;
      for (int i = 0; i < NSRC; i++) begin
         hc[i]++;
         if (hc[i] == 3 + 2 * i) begin
            hc[i] = 0;
            src_clk[i] = ~src_clk[i];
         end
      end
   end

   // reference model
   logic [NSRC-1:0] hist [$];
   int m_state, m_cur, m_gate, m_tgt, m_req;
   int m_dt, m_dc, m_up, m_dn, m_step, m_cnt, m_tcnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < SYNC; i++) hist.push_back('0);
         m_state = 0; m_cur = 0; m_gate = 1; m_tgt = 0; m_req = 0;
         m_dt = 0; m_dc = 0; m_up = 0; m_dn = 0; m_step = 0; m_cnt = 0; m_tcnt = 0;
      end else begin
         logic [NSRC-1:0] seen;
         int code;
         bit tk, en;
         seen = hist[0];
         code = int'(bus_wdata[10:8]);
         tk = (m_tcnt >= m_dc);
         m_tcnt = tk ? 0 : m_tcnt + 1;
         if (m_state == 0) begin
            if (bus_sel && bus_we && !bus_addr) begin
               m_req = code;
               if (bus_wdata[0] && src_ready[code] && code != m_cur) begin
                  m_tgt = code; m_state = 1;
               end
            end
         end else if (m_state == 1) begin
            if (!seen[m_cur]) begin m_gate = 0; m_state = 2; end
         end else begin
            if (!seen[m_tgt]) begin m_cur = m_tgt; m_gate = 1; m_state = 0; end
         end
         if (bus_sel && bus_we && bus_addr) begin
            m_dt = int'(bus_wdata[23:20]); m_up = int'(bus_wdata[2]);
            m_dn = int'(bus_wdata[1]); m_step = int'(bus_wdata[15:8]); m_cnt = 0;
         end else if (m_dc != m_dt) begin
            en = (m_dt > m_dc) ? (m_up != 0) : (m_dn != 0);
            if (!en) m_dc = m_dt;
            else if (m_cnt == m_step) begin
               m_cnt = 0;
               m_dc = (m_dt > m_dc) ? m_dc + 1 : m_dc - 1;
            end else m_cnt++;
         end
         hist.push_back(src_clk);
         void'(hist.pop_front());
      end
   end

   // cycle-by-cycle comparison on the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NSRC-1:0] vis;
         vis = hist[0];
         check("R5 sys_clk", {31'b0, sys_clk}, {31'b0, (m_gate != 0) && vis[m_cur]});
         check("R8 ratio", {28'b0, div_ratio}, 32'(m_dc));
         check("R10 tick", {31'b0, div_tick}, {31'b0, m_tcnt >= m_dc});
         if (!bus_addr)
            check("R4 ctrl read", bus_rdata,
                  32'((m_cur << 12) | (m_req << 8) | (m_state != 0 ? 1 : 0)));
         else
            check("R9 slew read", bus_rdata,
                  32'((m_dt << 20) | (m_step << 8) | (m_up << 2) | (m_dn << 1) | (m_dc != m_dt ? 1 : 0)));
      end
   end

   task automatic wr(logic a, logic [31:0] d);
      @(negedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wait_clear(string tag);
      int k = 0;
      @(negedge clk);
      while (bus_rdata[0] && k < 300) begin @(negedge clk); k++; end
      if (k >= 300) check(tag, 32'd1, 32'd0);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 ctrl reset", bus_rdata, 32'h0);
      #1 bus_addr = 1'b1;
      @(negedge clk);
      check("R1 slew reset", bus_rdata, 32'h0);
      check("R1 ratio reset", {28'b0, div_ratio}, 32'd0);

      // R2: source 6 not ready
      wr(1'b0, 32'h0000_0601);
      @(negedge clk);
      check("R2 reject", bus_rdata, 32'h0000_0600);
      // R3: same source
      wr(1'b0, 32'h0000_0001);
      @(negedge clk);
      check("R3 same source", bus_rdata, 32'h0000_0000);
      // R4: switch to 3, then R6: ignored write during pending switch
      wr(1'b0, 32'h0000_0301);
      @(negedge clk);
      check("R4 go set", bus_rdata, 32'h0000_0301);
      wr(1'b0, 32'h0000_0501);
      wait_clear("R4 switch timeout");
      check("R4 R6 after switch", bus_rdata, 32'h0000_3300);

      // R7: immediate change
      wr(1'b1, 32'h0050_0000);
      @(negedge clk);
      check("R7 busy after write", bus_rdata, 32'h0050_0001);
      @(negedge clk);
      check("R7 applied", {28'b0, div_ratio}, 32'd5);
      check("R9 busy clear", bus_rdata, 32'h0050_0000);
      // R8: upward slew, interval 3
      wr(1'b1, 32'h0090_0304);
      @(negedge clk);
      check("R8 ramp start", bus_rdata, 32'h0090_0305);
      check("R8 ratio hold", {28'b0, div_ratio}, 32'd5);
      repeat (4) @(negedge clk);
      check("R8 first step", {28'b0, div_ratio}, 32'd6);
      wait_clear("R8 ramp timeout");
      check("R8 ramp end", {28'b0, div_ratio}, 32'd9);
      // R8: downward change with only up stepping enabled jumps
      wr(1'b1, 32'h0020_0004);
      repeat (2) @(negedge clk);
      check("R8 down not slewed", {28'b0, div_ratio}, 32'd2);
      // R8: downward slew, interval 1
      wr(1'b1, 32'h0000_0102);
      repeat (3) @(negedge clk);
      check("R8 down step", {28'b0, div_ratio}, 32'd1);
      wait_clear("R8 down timeout");
      for (int i = 0; i < 3; i++) begin
         check("R10 tick every cycle", {31'b0, div_tick}, 32'd1);
         @(negedge clk);
      end

      // more switching
      #1 bus_addr = 1'b0;
      wr(1'b0, 32'h0000_0101);
      wait_clear("R4 switch timeout");
      check("R4 to source 1", bus_rdata, 32'h0000_1100);
      wr(1'b0, 32'h0000_0701);
      @(negedge clk);
      check("R2 reject 7", bus_rdata, 32'h0000_1700);
      wr(1'b0, 32'h0000_0501);
      wait_clear("R4 switch timeout");
      check("R4 to source 5", bus_rdata, 32'h0000_5500);

      wr(1'b1, 32'h00F0_0206);
      repeat (150) @(negedge clk);
      wr(1'b1, 32'h0030_0006);
      repeat (150) @(negedge clk);

      done = 1;
      report();
      $finish;
   end
endmodule